// File: doc/BRIEF.md
# Software-Controlled Clock Duty Modulator

This block throttles a downstream core by gating its per-cycle clock-enable with a programmable stop-clock duty cycle. Software programs a 64-bit control register through a simple write port and reads it back through a read port. The register holds an enable flag and a 3-bit duty code. A frame of eight clock slots repeats without stopping. Within each frame the clock-enable is high for the number of slots the active code selects and low for the rest, so the duty has a resolution of one-eighth.

A thermal monitor feeds in two signals: a hot status and a mode enable that carries its own 3-bit duty code. While both are asserted, the thermal code replaces the software setting, whether or not software modulation is on. A new setting is captured only when a frame ends, so the frame in progress always runs to completion unchanged. The gating acts on the internal clock-enable only and no external stop-clock pin takes part. The parameter `COUNT_STOPPED` selects what a code counts. At its default of 0 the code is the number of enabled slots, which come first in the frame. At 1 it is the number of stopped slots, which come first in the frame.

Top module: `clk_duty_mod`

## Requirements
- R1: After a synchronous reset the register reads 64'h2, with the enable flag at 0 and the duty code at 001. The slot counter is 0, and `core_clk_en` is high for the first frame.
- R2: A cycle with `wr_en` high loads bit 4 of `wr_data` as the enable flag and bits 3:1 as the duty code. `rd_data` shows them at the same positions from the next cycle on.
- R3: Bits 63:5 and bit 0 of `rd_data` always read 0, whatever was written to them.
- R4: Code 000, whether written by software or presented on `therm_code`, acts as code 001. A written 000 reads back as 001.
- R5: With software modulation enabled and no thermal throttle, every 8-cycle frame holds `core_clk_en` high in slots 0 to N-1 and low in slots N to 7, where N is the code.
- R6: While `therm_hot` and `therm_en` are both 1, the frame uses `therm_code`. This holds whatever the software enable flag and the software code are.
- R7: `therm_hot` without `therm_en`, or `therm_en` without `therm_hot`, has no effect on the pattern.
- R8: With software modulation off and no thermal throttle, `core_clk_en` stays high in every slot.
- R9: A change of code, enable or precedence takes effect only at the next frame boundary. The frame in progress completes with its old pattern.
- R10: The slot counter runs freely from 0 after reset and wraps every 8 cycles. Slot k of a frame is the k-th cycle after a multiple of 8 cycles since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | Register write value |
| rd_data | output | 64 | Register read value |
| therm_hot | input | 1 | Thermal hot status |
| therm_en | input | 1 | Thermal throttle mode enable |
| therm_code | input | 3 | Thermal duty code |
| core_clk_en | output | 1 | Per-cycle clock-enable for the core |

## Verification
The software codes are swept over all eight values, including the reserved 000, with the thermal pair idle. Every slot of a settled frame is compared against the arithmetic pattern, and this separates an off-by-one slot count from a wrong code mapping. The thermal codes are then swept while software sits at a conflicting code, and again with software disabled, which shows that precedence does not depend on the software flag. Each half-asserted thermal pair is also applied to confirm it is ignored. A change applied in mid-frame tells a boundary-aligned update apart from an immediate one, and writes of all ones and all zeros expose the reserved-bit handling in readback.

// File: rtl/clkmod_pkg.sv
package clkmod_pkg;
    localparam int CODE_W   = 3;
    localparam int SLOTS    = 1 << CODE_W;
    localparam int REG_W    = 64;
    localparam int EN_POS   = 4;
    localparam int CODE_LSB = 1;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic  on;
        code_t code;
    } ctrl_t;

    typedef struct packed {
        logic  mod_on;
        code_t slots;
    } frame_cfg_t;

    localparam code_t DEFAULT_CODE = code_t'(1);

    function automatic code_t fix_code(input code_t c);
        return (c == '0) ? DEFAULT_CODE : c;
    endfunction
endpackage

// File: rtl/clkmod_ctrl_reg.sv
module clkmod_ctrl_reg
    import clkmod_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctrl_t            ctrl,
    output logic [REG_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.on   <= 1'b0;
            ctrl.code <= DEFAULT_CODE;
        end else if (wr_en) begin
            ctrl.on   <= wr_data[EN_POS];
            ctrl.code <= fix_code(wr_data[CODE_LSB +: CODE_W]);
        end
    end

    always_comb begin
        rd_data                      = '0;
        rd_data[EN_POS]              = ctrl.on;
        rd_data[CODE_LSB +: CODE_W]  = ctrl.code;
    end
endmodule

// File: rtl/clkmod_frame_ctr.sv
module clkmod_frame_ctr
    import clkmod_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output code_t slot,
    output logic  frame_end
);
    always_ff @(posedge clk) begin
        if (rst) slot <= '0;
        else     slot <= slot + 1'b1;
    end

    assign frame_end = (slot == code_t'(SLOTS - 1));
endmodule

// File: rtl/clkmod_duty_gen.sv
module clkmod_duty_gen
    import clkmod_pkg::*;
#(
    parameter bit COUNT_STOPPED = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_end,
    input  code_t      slot,
    input  ctrl_t      ctrl,
    input  logic       therm_hot,
    input  logic       therm_en,
    input  code_t      therm_code,
    output frame_cfg_t cfg,
    output logic       clk_en
);
    frame_cfg_t next_cfg;
    logic       in_count;

    always_comb begin
        if (therm_hot && therm_en) begin
            next_cfg.mod_on = 1'b1;
            next_cfg.slots  = fix_code(therm_code);
        end else if (ctrl.on) begin
            next_cfg.mod_on = 1'b1;
            next_cfg.slots  = fix_code(ctrl.code);
        end else begin
            next_cfg.mod_on = 1'b0;
            next_cfg.slots  = DEFAULT_CODE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.mod_on <= 1'b0;
            cfg.slots  <= DEFAULT_CODE;
        end else if (frame_end) begin
            cfg <= next_cfg;
        end
    end

    assign in_count = (slot < cfg.slots);

    generate
        if (COUNT_STOPPED) begin : g_stop_count
            assign clk_en = !cfg.mod_on || !in_count;
        end else begin : g_run_count
            assign clk_en = !cfg.mod_on || in_count;
        end
    endgenerate
endmodule

// File: rtl/clk_duty_mod.sv
module clk_duty_mod
    import clkmod_pkg::*;
#(
    parameter bit COUNT_STOPPED = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [63:0] wr_data,
    output logic [63:0] rd_data,
    input  logic        therm_hot,
    input  logic        therm_en,
    input  logic [2:0]  therm_code,
    output logic        core_clk_en
);
    ctrl_t      ctrl;
    code_t      slot;
    logic       frame_end;
    frame_cfg_t cfg;

    clkmod_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .rd_data (rd_data)
    );

    clkmod_frame_ctr u_ctr (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .frame_end (frame_end)
    );

    clkmod_duty_gen #(.COUNT_STOPPED(COUNT_STOPPED)) u_gen (
        .clk        (clk),
        .rst        (rst),
        .frame_end  (frame_end),
        .slot       (slot),
        .ctrl       (ctrl),
        .therm_hot  (therm_hot),
        .therm_en   (therm_en),
        .therm_code (therm_code),
        .cfg        (cfg),
        .clk_en     (core_clk_en)
    );
endmodule

// File: rtl/clk_duty_mod_chk.sv
module clk_duty_mod_chk
    import clkmod_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [63:0] wr_data,
    input logic [63:0] rd_data,
    input logic        therm_hot,
    input logic        therm_en,
    input logic [2:0]  therm_code,
    input logic        core_clk_en,
    input code_t       slot,
    input logic        frame_end,
    input frame_cfg_t  cfg
);
    // R1: reset leaves the register at its default and the counter at slot 0
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (rd_data == 64'h2 && slot == '0 && core_clk_en));

    // R2: a written enable bit shows up on the read port next cycle
    p_write_en_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[4] == $past(wr_data[4])));

    // R3: reserved positions stay zero after any write
    p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[63:5] == '0 && rd_data[0] == 1'b0));

    // R4: a written code of zero is stored as 001
    p_zero_code_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[3:1] == 3'b000) |=> (rd_data[3:1] == 3'b001));

    // R10: the slot counter steps by one every cycle
    p_slot_step_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (slot == code_t'($past(slot) + 1'b1)));

    // R9: the active frame setting changes only after a frame end
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(frame_end)) |-> $stable(cfg));

    // R6: a thermal throttle seen at a frame end sets the next frame's code
    p_therm_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (frame_end && therm_hot && therm_en) |=>
            (cfg.mod_on && cfg.slots == fix_code($past(therm_code))));

    // R8: no modulation means the enable stays high
    p_idle_high_r8: assert property (@(posedge clk) disable iff (rst)
        !cfg.mod_on |-> core_clk_en);
endmodule

bind clk_duty_mod clk_duty_mod_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .therm_hot   (therm_hot),
    .therm_en    (therm_en),
    .therm_code  (therm_code),
    .core_clk_en (core_clk_en),
    .slot        (slot),
    .frame_end   (frame_end),
    .cfg         (cfg)
);

// File: tb/clk_duty_mod_bench.sv
module clk_duty_mod_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        therm_hot = 1'b0;
    logic        therm_en = 1'b0;
    logic [2:0]  therm_code = 3'd0;
    logic        core_clk_en;

    int checks = 0;
    int fails  = 0;
    int bc     = 0;   // cycles since reset release (R10 model)
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    clk_duty_mod u_clk_duty_mod (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .therm_hot   (therm_hot),
        .therm_en    (therm_en),
        .therm_code  (therm_code),
        .core_clk_en (core_clk_en)
    );

    always @(posedge clk) begin
        if (rst) bc <= 0;
        else     bc <= bc + 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [63:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // wait until a frame begins that was fully set up after the last change
    task automatic settle();
        @(negedge clk);
        @(negedge clk);
        while (bc % 8 != 0) @(negedge clk);
    endtask

    // expected enable in slot s for n active slots; n = 0 means unmodulated
    function automatic bit exp_en(input int n, input int s);
        return (n == 0) ? 1'b1 : (s < n);
    endfunction

    // check one full frame, starting at the current negedge (slot 0)
    task automatic frame_check(input int n, input string req);
        for (int s = 0; s < 8; s++) begin
            chk(core_clk_en == exp_en(n, s), req, core_clk_en, exp_en(n, s));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(rd_data == 64'h2, "R1", rd_data, 64'h2);
        chk(bc == 1, "R10", bc, 1);
        for (int s = 1; s < 8; s++) begin
            chk(core_clk_en == 1'b1, "R1", core_clk_en, 1);
            @(negedge clk);
        end

        // R2/R3: readback and reserved bits
        reg_write(64'hFFFF_FFFF_FFFF_FFFF);
        chk(rd_data == 64'h1E, "R3", rd_data, 64'h1E);
        reg_write(64'h0000_0000_0000_000A);
        chk(rd_data == 64'h0A, "R2", rd_data, 64'h0A);
        reg_write(64'hA5A5_A5A5_A5A5_A5B5);
        chk(rd_data == 64'h14, "R3", rd_data, 64'h14);
        reg_write(64'h0000_0000_0000_0010);
        chk(rd_data == 64'h12, "R4", rd_data, 64'h12);   // 000 stored as 001

        // R8: disabled -> always high
        reg_write(64'h0000_0000_0000_000C);
        settle();
        frame_check(0, "R8");

        // R5/R4: sweep all software codes
        for (int c = 0; c < 8; c++) begin
            reg_write(64'h10 | (64'(c) << 1));
            settle();
            frame_check((c == 0) ? 1 : c, (c == 0) ? "R4" : "R5");
        end

        // R7: half-asserted thermal pair ignored (software code 3)
        reg_write(64'h10 | (64'd3 << 1));
        therm_code = 3'd7; therm_hot = 1'b1; therm_en = 1'b0;
        settle();
        frame_check(3, "R7");
        therm_hot = 1'b0; therm_en = 1'b1;
        settle();
        frame_check(3, "R7");

        // R6: thermal overrides software, enabled or not
        for (int c = 0; c < 8; c++) begin
            therm_hot = 1'b1; therm_en = 1'b1; therm_code = 3'(c);
            reg_write((c % 2 == 0) ? (64'h10 | (64'd5 << 1)) : 64'h0);
            settle();
            frame_check((c == 0) ? 1 : c, (c == 0) ? "R4" : "R6");
        end
        therm_hot = 1'b0; therm_en = 1'b0;

        // R9: mid-frame change waits for the frame boundary
        reg_write(64'h10 | (64'd2 << 1));
        settle();
        frame_check(2, "R9");
        for (int s = 0; s < 3; s++) begin
            chk(core_clk_en == exp_en(2, s), "R9", core_clk_en, exp_en(2, s));
            @(negedge clk);
        end
        therm_hot = 1'b1; therm_en = 1'b1; therm_code = 3'd6;
        for (int s = 3; s < 8; s++) begin
            chk(core_clk_en == exp_en(2, s), "R9", core_clk_en, exp_en(2, s));
            @(negedge clk);
        end
        chk(bc % 8 == 0, "R10", bc % 8, 0);
        frame_check(6, "R9");
        // release mid-frame: current frame still at 6
        repeat (2) @(negedge clk);
        therm_hot = 1'b0; therm_en = 1'b0;
        for (int s = 2; s < 8; s++) begin
            chk(core_clk_en == exp_en(6, s), "R9", core_clk_en, exp_en(6, s));
            @(negedge clk);
        end
        frame_check(2, "R9");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule